// File: doc/BRIEF.md
# Multiphase Sampling Time Digitizer

This block is a single-channel time-to-digital converter that reports where the leading edge of a hit lands inside one bunch-crossing period. It needs no delay line and no fast counter. Two Johnson-code phase generators run from the 8x clock: one changes on the rising edge and the other on the falling edge. Between them they give each of the sixteen half-periods of the 8x clock its own pattern. The rising edge of the asynchronous hit input freezes both generators into a capture register. A decoder turns that pattern into a 4-bit bin number, where each bin is 25 ns / 16 = 1.5625 ns at the nominal rate.

Validation alternates between the two halves of a crossing. A capture from the first half (bins 0..7) is judged at the sixth rising 8x edge of that crossing. A capture from the second half (bins 8..15) is judged at the second rising 8x edge of the next crossing. At the middle of the following crossing, an output register presents the first accepted hit of each crossing for exactly one crossing. Only the 8x clock is needed: the half-period phase information is already present in the counter state, so no slower clock is used. Bunch crossing 0 begins at the second rising 8x edge after `rst_n` is released. Every later crossing begins eight rising edges after the one before.

Top module: `mphase_tdc`

## Requirements
- R1: While `rst_n` is low, `hit_valid` is 0 and `fine_time` is 0.
- R2: A hit edge in half-period p of a crossing is reported with `fine_time` = p. Half-period p lies after rising 8x edge p/2 of the crossing when p is even, and after the falling edge that follows it when p is odd. Rising edge 0 is the first edge of the crossing.
- R3: The report for hits of crossing n appears at rising 8x edge 4 of crossing n+1. It is held unchanged until rising edge 4 of crossing n+2.
- R4: A crossing with no accepted hit gives `hit_valid` = 0 and `fine_time` = 0 in its report slot.
- R5: A hit edge that arrives while an earlier capture is still awaiting validation is ignored, and the earlier value is the one reported.
- R6: At most one hit is reported per crossing, and it is the earliest accepted one. A second-half capture made after a first-half capture of the same crossing is validated but discarded.
- R7: The capture stays blind after a first-half capture through bin 11 of the same crossing. After a second-half capture it stays blind through bin 3 of the next crossing. Hit edges after that are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_8x | input | 1 | Timing clock at eight times the crossing rate, phase-locked to it |
| rst_n | input | 1 | Active-low reset; asserts at once, releases after two 8x rising edges |
| hit_in | input | 1 | Asynchronous hit; its rising edge is measured |
| fine_time | output | 4 | Bin of the reported hit inside its crossing, 0 when nothing is reported |
| hit_valid | output | 1 | High for one crossing when a hit is reported |

## Verification
The assertions assume that the hit input rises well away from any 8x clock edge, so that the two phase codes are stable when frozen. They also assume that a hit rising edge is never coincident with a validation edge. The stimulus places every hit rising edge 2 ns after the 8x edge that opens its half-period and keeps it high for 1 ns, so each edge sits well inside one bin. The random crossings choose up to three bins per crossing. A reference model in the bench tracks the blind windows and the earliest-hit rule to predict each slot.

// File: rtl/mptdc_pkg.sv
`timescale 1ns/1ps
package mptdc_pkg;

  // Kind of 8x rising edge, derived from the rising-edge phase code.
  typedef enum logic [1:0] {
    EK_IDLE  = 2'd0,
    EK_EARLY = 2'd1,   // judges first-half captures
    EK_LATE  = 2'd2,   // judges second-half captures
    EK_SLOT  = 2'd3    // loads the output register
  } edge_kind_e;

  // Johnson code of step idx for a w-bit counter (w <= 16), zero-extended.
  function automatic logic [15:0] jc_code(input int unsigned idx, input int unsigned w);
    logic [15:0] c;
    c = '0;
    for (int unsigned b = 0; b < 16; b++) begin
      if (b < w) begin
        if (idx <= w) c[b] = (b < idx);
        else          c[b] = (b >= idx - w);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/mptdc_phase_gen.sv
`timescale 1ns/1ps
module mptdc_phase_gen #(
  parameter int JW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [JW-1:0] ph_rise,
  output logic [JW-1:0] ph_fall
);
  import mptdc_pkg::*;

  localparam logic [JW-1:0] FALL_RST = JW'(jc_code(2 * JW - 1, JW));

  logic [JW-1:0] rise_nxt;

  always_comb begin
    rise_nxt = {ph_rise[JW-2:0], ~ph_rise[JW-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_rise <= '0;
    else        ph_rise <= rise_nxt;
  end

  // The falling-edge generator trails by half an 8x period.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ph_fall <= FALL_RST;
    else        ph_fall <= ph_rise;
  end

  AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ph_fall == ph_rise); // R2

endmodule

// File: rtl/mptdc_hit_catch.sv
`timescale 1ns/1ps
module mptdc_hit_catch #(
  parameter int PW = 8
) (
  input  logic          hit_in,
  input  logic          rst_n,
  input  logic          rearm,
  input  logic [PW-1:0] phase_pat,
  output logic          caught,
  output logic [PW-1:0] snap
);

  logic arm_n;

  always_comb begin
    arm_n = rst_n & ~rearm;
  end

  // Set by a hit edge, cleared asynchronously when the judge rearms.
  always_ff @(posedge hit_in or negedge arm_n) begin
    if (!arm_n) caught <= 1'b0;
    else        caught <= 1'b1;
  end

  // Frozen phase codes; an edge that finds a capture pending leaves them.
  always_ff @(posedge hit_in or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (!caught) snap <= phase_pat;
  end

endmodule

// File: rtl/mptdc_hit_judge.sv
`timescale 1ns/1ps
module mptdc_hit_judge #(
  parameter int JW = 4,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [JW-1:0] ph_rise,
  input  logic          caught,
  input  logic [2*JW-1:0] snap,
  output logic          rearm,
  output logic [FW-1:0] fine_time,
  output logic          hit_valid
);
  import mptdc_pkg::*;

  localparam int            NSTEP   = 2 * JW;
  localparam logic [JW-1:0] J_EARLY = JW'(jc_code(JW, JW));
  localparam logic [JW-1:0] J_LATE  = JW'(jc_code(0, JW));
  localparam logic [JW-1:0] J_SLOT  = JW'(jc_code(JW - 1, JW));
  localparam logic [FW-1:0] HALF    = FW'(NSTEP);

  edge_kind_e    ek;
  logic          dec_ok, dec_late, half_match;
  logic [FW-1:0] dec_f;
  logic [JW-1:0] snap_r, snap_f;

  logic          pend_v, pend_v_nxt;
  logic [FW-1:0] pend_f, pend_f_nxt;
  logic          rearm_nxt, val_nxt;
  logic [FW-1:0] fine_nxt;

  always_comb begin
    snap_r = snap[2*JW-1:JW];
    snap_f = snap[JW-1:0];
  end

  always_comb begin
    if      (ph_rise == J_EARLY) ek = EK_EARLY;
    else if (ph_rise == J_LATE)  ek = EK_LATE;
    else if (ph_rise == J_SLOT)  ek = EK_SLOT;
    else                         ek = EK_IDLE;
  end

  // Pattern decode: rising code picks the 8x step, falling code the half.
  always_comb begin
    logic [JW-1:0] c_cur, c_prv;
    dec_ok = 1'b0;
    dec_f  = '0;
    for (int i = 0; i < NSTEP; i++) begin
      c_cur = JW'(jc_code(i, JW));
      c_prv = JW'(jc_code((i + NSTEP - 1) % NSTEP, JW));
      if (snap_r == c_cur) begin
        if (snap_f == c_cur) begin
          dec_ok = 1'b1;
          dec_f  = FW'(2 * i + 1);
        end else if (snap_f == c_prv) begin
          dec_ok = 1'b1;
          dec_f  = FW'(2 * i);
        end
      end
    end
    dec_late   = (dec_f >= HALF);
    half_match = ((ek == EK_EARLY) && !dec_late) || ((ek == EK_LATE) && dec_late);
  end

  always_comb begin
    rearm_nxt  = 1'b0;
    pend_v_nxt = pend_v;
    pend_f_nxt = pend_f;
    val_nxt    = hit_valid;
    fine_nxt   = fine_time;
    if (ek == EK_SLOT) begin
      val_nxt    = pend_v;
      fine_nxt   = pend_v ? pend_f : '0;
      pend_v_nxt = 1'b0;
      pend_f_nxt = '0;
    end
    if (caught && (ek == EK_EARLY || ek == EK_LATE)) begin
      if (!dec_ok) begin
        rearm_nxt = 1'b1;
      end else if (half_match) begin
        rearm_nxt = 1'b1;
        if (!pend_v) begin
          pend_v_nxt = 1'b1;
          pend_f_nxt = dec_f;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rearm     <= 1'b0;
      pend_v    <= 1'b0;
      pend_f    <= '0;
      hit_valid <= 1'b0;
      fine_time <= '0;
    end else begin
      rearm     <= rearm_nxt;
      pend_v    <= pend_v_nxt;
      pend_f    <= pend_f_nxt;
      hit_valid <= val_nxt;
      fine_time <= fine_nxt;
    end
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ek != EK_SLOT) |=> ($stable(hit_valid) && $stable(fine_time))); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> (fine_time == '0)); // R4
  AST_SLOT_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
    (ek == EK_SLOT) |=> !pend_v); // R6
  AST_REARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !rearm); // R7

endmodule

// File: rtl/mphase_tdc.sv
`timescale 1ns/1ps
module mphase_tdc #(
  parameter int JW = 4
) (
  input  logic                     clk_8x,
  input  logic                     rst_n,
  input  logic                     hit_in,
  output logic [$clog2(4*JW)-1:0]  fine_time,
  output logic                     hit_valid
);

  localparam int FW = $clog2(4 * JW);
  localparam int PW = 2 * JW;

  logic [1:0]    rst_sync;
  logic          rst_s_n;
  logic [JW-1:0] ph_rise, ph_fall;
  logic          caught, rearm;
  logic [PW-1:0] snap;

  always_ff @(posedge clk_8x or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  always_comb begin
    rst_s_n = rst_sync[1];
  end

  mptdc_phase_gen #(.JW(JW)) u_phase (
    .clk     (clk_8x),
    .rst_n   (rst_s_n),
    .ph_rise (ph_rise),
    .ph_fall (ph_fall)
  );

  mptdc_hit_catch #(.PW(PW)) u_catch (
    .hit_in    (hit_in),
    .rst_n     (rst_s_n),
    .rearm     (rearm),
    .phase_pat ({ph_rise, ph_fall}),
    .caught    (caught),
    .snap      (snap)
  );

  mptdc_hit_judge #(.JW(JW), .FW(FW)) u_judge (
    .clk       (clk_8x),
    .rst_n     (rst_s_n),
    .ph_rise   (ph_rise),
    .caught    (caught),
    .snap      (snap),
    .rearm     (rearm),
    .fine_time (fine_time),
    .hit_valid (hit_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_8x)
    !rst_n |-> (!hit_valid && fine_time == '0)); // R1

endmodule

// File: tb/test_mphase_tdc.sv
`timescale 1ns/1ps
module test_mphase_tdc;

  localparam int NBX = 300;

  logic       clk_8x = 1'b0;
  logic       rst_n  = 1'b0;
  logic       hit_in = 1'b0;
  logic [3:0] fine_time;
  logic       hit_valid;

  always #5 clk_8x = ~clk_8x;

  mphase_tdc #(.JW(4)) i_mphase_tdc (
    .clk_8x    (clk_8x),
    .rst_n     (rst_n),
    .hit_in    (hit_in),
    .fine_time (fine_time),
    .hit_valid (hit_valid)
  );

  int    n_chk = 0;
  int    n_err = 0;
  int    free_at = 0;
  int    bx = 0;
  bit    exp_v [NBX];
  int    exp_f [NBX];
  string exp_t [NBX];

  task automatic chk(string tag, logic gv, logic [3:0] gf, bit ev, logic [3:0] ef);
    n_chk++;
    if (gv !== ev || gf !== ef) begin
      n_err++;
      $display("FAIL %s at bx %0d: actual valid=%0b fine=%0d expected valid=%0b fine=%0d",
               tag, bx, gv, gf, ev, ef);
    end
  endtask

  // Reference: blind windows (R7), ignored edges (R5), earliest wins (R6).
  task automatic model(int n, logic [15:0] mask, string tag);
    bit got = 1'b0;
    exp_v[n+1] = 1'b0;
    exp_f[n+1] = 0;
    exp_t[n+1] = (mask == 16'd0) ? "R4" : tag;
    for (int p = 0; p < 16; p++) begin
      if (mask[p] && (16 * n + p >= free_at)) begin
        free_at = (p < 8) ? 16 * n + 12 : 16 * n + 20;
        if (!got) begin
          got = 1'b1;
          exp_v[n+1] = 1'b1;
          exp_f[n+1] = p;
        end
      end
    end
  endtask

  task automatic pulse();
    #2 hit_in = 1'b1;
    #1 hit_in = 1'b0;
  endtask

  task automatic run_bx(logic [15:0] mask, string tag);
    model(bx, mask, tag);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk_8x);
      if (mask[2*k]) pulse();
      @(negedge clk_8x);
      if (k == 3) begin
        if (bx >= 1) chk("R3", hit_valid, fine_time, exp_v[bx-1], 4'(exp_f[bx-1]));
        else         chk("R3", hit_valid, fine_time, 1'b0, 4'd0);
      end
      if (k == 4) chk(exp_t[bx], hit_valid, fine_time, exp_v[bx], 4'(exp_f[bx]));
      if (mask[2*k+1]) pulse();
    end
    bx++;
  endtask

  initial begin
    repeat (200000) @(posedge clk_8x);
    n_err++;
    $display("FAIL R3 watchdog: actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] m;
    void'($urandom(32'd7741));
    exp_v[0] = 1'b0;
    exp_f[0] = 0;
    exp_t[0] = "R4";
    repeat (3) @(posedge clk_8x);
    @(negedge clk_8x);
    chk("R1", hit_valid, fine_time, 1'b0, 4'd0);
    pulse();
    @(negedge clk_8x);
    chk("R1", hit_valid, fine_time, 1'b0, 4'd0);
    rst_n = 1'b1;
    @(posedge clk_8x);
    run_bx(16'h0000, "R4");
    run_bx(16'h0000, "R4");
    // R2: every bin on its own
    for (int p = 0; p < 16; p++) run_bx(16'(1 << p), "R2");
    run_bx(16'h0000, "R4");
    // R5: a second edge while the first capture waits
    run_bx(16'h0024, "R5");
    run_bx(16'h0000, "R4");
    run_bx(16'h0A00, "R5");
    run_bx(16'h0000, "R4");
    // R6: late capture discarded after an early one
    run_bx(16'h2008, "R6");
    // R7: bins 0..3 blind after the discarded late capture, bin 6 accepted
    run_bx(16'h0042, "R7");
    run_bx(16'h0000, "R4");
    run_bx(16'h0400, "R7");
    run_bx(16'h0008, "R7");
    run_bx(16'h1000, "R7");
    run_bx(16'h0010, "R7");
    run_bx(16'h0000, "R4");
    run_bx(16'h0820, "R7");
    run_bx(16'h0000, "R4");
    run_bx(16'h1020, "R6");
    run_bx(16'h0000, "R4");
    for (int i = 0; i < 200; i++) begin
      m = '0;
      for (int h = 0; h < int'($urandom_range(0, 3)); h++) m[$urandom_range(0, 15)] = 1'b1;
      run_bx(m, "R2");
    end
    run_bx(16'h0000, "R4");
    run_bx(16'h0000, "R4");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule